// File: doc/BRIEF.md
# IEEE Double Operand Screener

This combinational stage sits in front of a double-precision floating-point unit and inspects one 64-bit source operand on its way in. It recognises denormals, infinities and NaNs from the exponent and fraction fields. Based on the selected screening policy, it either passes the operand through, flushes a denormal to a zero of the same sign, or raises a trap request with a one-hot cause code. It does no arithmetic and does not deliver traps; a downstream unit uses the request and code.

Three policies are available. The plain policy traps on any non-finite input. The compare policy lets infinities through and traps only on NaNs. The software-completion policy never traps and only applies the flush. An operand read from the hardwired-zero register bypasses all screening and comes out as zero.

Top module: `fp_operand_screen`

## Requirements
- R1: The exponent is operand bits 62:52, the fraction is bits 51:0 and the sign is bit 63. When the exponent is neither all-zeros nor all-ones, the operand is output unchanged, the trap request is 0 and the trap code is 3'b000.
- R2: Plain or compare policy: an all-zero exponent with a nonzero fraction and the flush enable high outputs the sign bit followed by 63 zeros, with no trap.
- R3: Plain or compare policy: an all-zero exponent with a nonzero fraction and the flush enable low raises a trap with code 3'b100 (underflow). The operand is output unchanged.
- R4: Plain policy, all-ones exponent: a nonzero fraction traps with code 3'b001 (invalid). A zero fraction traps with code 3'b010 (overflow). The operand is output unchanged in both cases.
- R5: Compare policy, all-ones exponent: a nonzero fraction traps with code 3'b001. A zero fraction (infinity) passes unchanged with no trap.
- R6: Software-completion policy never raises a trap. With the flush enable high and an all-zero exponent, it outputs only the sign bit. Every other input is output unchanged.
- R7: When the software-completion and compare selects are both high, the software-completion policy applies.
- R8: When the zero-register flag is high, the output is all zeros, the request is 0 and the code is 0, whatever the other inputs are.
- R9: The trap request is high exactly when the trap code is nonzero, and the code has at most one bit set.
- R10: A signed zero (+0 or -0) is output unchanged with no trap under every policy and flush setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 64 | Source operand in double-precision format |
| src_zero_reg_i | input | 1 | Operand comes from the hardwired-zero register |
| flush_en_i | input | 1 | Flush denormal inputs to signed zero |
| swc_sel_i | input | 1 | Select the software-completion policy |
| cmp_sel_i | input | 1 | Select the compare policy |
| opnd_o | output | 64 | Screened operand |
| trap_req_o | output | 1 | Arithmetic trap request |
| trap_code_o | output | 3 | One-hot cause: [0] invalid, [1] overflow, [2] underflow |

## Verification
The checker tests every input combination as it occurs. It covers the zero-register override, the rule that software completion never traps, the one-hot code and its agreement with the request, the pass-through of finite values and the infinity pass-through in compare mode. Exact output values for denormal flushes and the choice of cause code per operand class are shown by the bench. The bench compares directed vectors and random vectors, biased toward each exponent class, against its own reference model. Those vectors include signed zeros, infinities, both NaN kinds and the case where both policy selects are high.

// File: rtl/fp_screen_pkg.sv
package fp_screen_pkg;

    parameter int EXP_W  = 11;
    parameter int FRAC_W = 52;
    localparam int DW       = 1 + EXP_W + FRAC_W;
    localparam int SIGN_POS = DW - 1;
    localparam int EXP_LSB  = FRAC_W;
    localparam int CODE_W   = 3;

    // one-hot trap cause positions
    localparam int CAUSE_INV = 0;
    localparam int CAUSE_OVF = 1;
    localparam int CAUSE_UNF = 2;

    typedef logic [DW-1:0]     word_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic sign;
        logic exp_zero;
        logic exp_ones;
        logic frac_nz;
    } opnd_class_t;

    typedef enum logic [1:0] {
        POL_PLAIN = 2'd0,
        POL_CMP   = 2'd1,
        POL_SWC   = 2'd2
    } policy_e;

    typedef enum logic [1:0] {
        ACT_PASS  = 2'd0,
        ACT_FLUSH = 2'd1,
        ACT_ZERO  = 2'd2
    } action_e;

    typedef struct packed {
        action_e act;
        code_t   code;
    } verdict_t;

    function automatic code_t cause_bit(input int pos);
        code_t c;
        c = '0;
        c[pos] = 1'b1;
        return c;
    endfunction

    function automatic policy_e pick_policy(input logic swc, input logic cmp);
        if (swc)      return POL_SWC;
        else if (cmp) return POL_CMP;
        else          return POL_PLAIN;
    endfunction

endpackage

// File: rtl/fp_screen_classify.sv
module fp_screen_classify
    import fp_screen_pkg::*;
(
    input  word_t       opnd,
    output opnd_class_t cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f        = opnd[EXP_LSB +: EXP_W];
        frac_f       = opnd[FRAC_W-1:0];
        cls.sign     = opnd[SIGN_POS];
        cls.exp_zero = (exp_f == '0);
        cls.exp_ones = &exp_f;
        cls.frac_nz  = |frac_f;
    end
endmodule

// File: rtl/fp_screen_policy.sv
module fp_screen_policy
    import fp_screen_pkg::*;
(
    input  opnd_class_t cls,
    input  policy_e     pol,
    input  logic        zero_reg,
    input  logic        flush_en,
    output verdict_t    vd
);
    always_comb begin
        vd.act  = ACT_PASS;
        vd.code = '0;
        if (zero_reg) begin
            vd.act = ACT_ZERO;
        end else begin
            unique case (pol)
                POL_SWC: begin
                    if (flush_en && cls.exp_zero) vd.act = ACT_FLUSH;
                end
                POL_PLAIN, POL_CMP: begin
                    if (cls.exp_zero && cls.frac_nz) begin
                        if (flush_en) vd.act  = ACT_FLUSH;
                        else          vd.code = cause_bit(CAUSE_UNF);
                    end else if (cls.exp_ones) begin
                        if (cls.frac_nz)         vd.code = cause_bit(CAUSE_INV);
                        else if (pol == POL_PLAIN) vd.code = cause_bit(CAUSE_OVF);
                    end
                end
                default: vd.act = ACT_PASS;
            endcase
        end
    end
endmodule

// File: rtl/fp_operand_screen.sv
module fp_operand_screen
    import fp_screen_pkg::*;
(
    input  logic [63:0] opnd_i,
    input  logic        src_zero_reg_i,
    input  logic        flush_en_i,
    input  logic        swc_sel_i,
    input  logic        cmp_sel_i,
    output logic [63:0] opnd_o,
    output logic        trap_req_o,
    output logic [2:0]  trap_code_o
);
    opnd_class_t cls;
    verdict_t    vd;
    policy_e     pol;

    assign pol = pick_policy(swc_sel_i, cmp_sel_i);

    fp_screen_classify u_cls (
        .opnd (opnd_i),
        .cls  (cls)
    );

    fp_screen_policy u_pol (
        .cls      (cls),
        .pol      (pol),
        .zero_reg (src_zero_reg_i),
        .flush_en (flush_en_i),
        .vd       (vd)
    );

    always_comb begin
        unique case (vd.act)
            ACT_ZERO:  opnd_o = '0;
            ACT_FLUSH: opnd_o = {cls.sign, {(DW-1){1'b0}}};
            default:   opnd_o = opnd_i;
        endcase
        trap_code_o = vd.code;
        trap_req_o  = |vd.code;
    end
endmodule

// File: rtl/fp_operand_screen_chk.sv
module fp_operand_screen_chk (
    input logic [63:0] opnd_i,
    input logic        src_zero_reg_i,
    input logic        flush_en_i,
    input logic        swc_sel_i,
    input logic        cmp_sel_i,
    input logic [63:0] opnd_o,
    input logic        trap_req_o,
    input logic [2:0]  trap_code_o
);
    logic exp_mid, exp_max;
    assign exp_mid = (opnd_i[62:52] != 11'h000) && (opnd_i[62:52] != 11'h7ff);
    assign exp_max = (opnd_i[62:52] == 11'h7ff);

    always_comb begin
        if (!$isunknown({opnd_i, src_zero_reg_i, flush_en_i, swc_sel_i, cmp_sel_i})) begin
            if (src_zero_reg_i)
                assert_zero_reg_R8: assert (opnd_o == 64'd0 && !trap_req_o && trap_code_o == 3'd0);
            assert_req_code_R9: assert (trap_req_o == (trap_code_o != 3'd0) && $onehot0(trap_code_o));
            if (!src_zero_reg_i && swc_sel_i)
                assert_swc_notrap_R6: assert (!trap_req_o);
            if (!src_zero_reg_i && swc_sel_i && cmp_sel_i && exp_max)
                assert_swc_wins_R7: assert (!trap_req_o && opnd_o == opnd_i);
            if (!src_zero_reg_i && exp_mid)
                assert_finite_pass_R1: assert (opnd_o == opnd_i && !trap_req_o);
            if (!src_zero_reg_i && !swc_sel_i && cmp_sel_i && exp_max && opnd_i[51:0] == 52'd0)
                assert_cmp_inf_R5: assert (!trap_req_o && opnd_o == opnd_i);
            if (!src_zero_reg_i && opnd_i[62:0] == 63'd0)
                assert_signed_zero_R10: assert (opnd_o == opnd_i && !trap_req_o);
        end
    end
endmodule

bind fp_operand_screen fp_operand_screen_chk u_chk (
    .opnd_i         (opnd_i),
    .src_zero_reg_i (src_zero_reg_i),
    .flush_en_i     (flush_en_i),
    .swc_sel_i      (swc_sel_i),
    .cmp_sel_i      (cmp_sel_i),
    .opnd_o         (opnd_o),
    .trap_req_o     (trap_req_o),
    .trap_code_o    (trap_code_o)
);

// File: tb/fp_operand_screen_tb.sv
module fp_operand_screen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] opnd_i = '0;
    logic        src_zero_reg_i = 1'b0;
    logic        flush_en_i = 1'b0;
    logic        swc_sel_i = 1'b0;
    logic        cmp_sel_i = 1'b0;
    logic [63:0] opnd_o;
    logic        trap_req_o;
    logic [2:0]  trap_code_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fp_operand_screen u_dut (
        .opnd_i(opnd_i), .src_zero_reg_i(src_zero_reg_i), .flush_en_i(flush_en_i),
        .swc_sel_i(swc_sel_i), .cmp_sel_i(cmp_sel_i),
        .opnd_o(opnd_o), .trap_req_o(trap_req_o), .trap_code_o(trap_code_o)
    );

    function automatic logic [67:0] ref_model(input logic [63:0] v, input logic z,
                                              input logic daz, input logic swc, input logic cmp);
        logic [10:0] e;
        logic [51:0] f;
        logic [63:0] o;
        logic [2:0]  c;
        e = v[62:52]; f = v[51:0]; o = v; c = 3'b000;
        if (z) o = '0;
        else if (swc) begin
            if (daz && e == 11'h000) o = {v[63], 63'd0};
        end else if (e == 11'h000 && f != 0) begin
            if (daz) o = {v[63], 63'd0};
            else     c = 3'b100;
        end else if (e == 11'h7ff) begin
            if (f != 0)   c = 3'b001;
            else if (!cmp) c = 3'b010;
        end
        return {o, (c != 3'b000), c};
    endfunction

    function automatic string tag_of(input logic [63:0] v, input logic z,
                                     input logic daz, input logic swc, input logic cmp);
        if (z)   return "R8";
        if (swc) return cmp ? "R7" : "R6";
        if (v[62:0] == 63'd0) return "R10";
        if (v[62:52] == 11'h000) return daz ? "R2" : "R3";
        if (v[62:52] == 11'h7ff) return cmp ? "R5" : "R4";
        return "R1";
    endfunction

    task automatic apply(input logic [63:0] v, input logic z, input logic daz,
                         input logic swc, input logic cmp, input string tag);
        logic [67:0] exp_v;
        @(posedge clk);
        opnd_i = v; src_zero_reg_i = z; flush_en_i = daz; swc_sel_i = swc; cmp_sel_i = cmp;
        @(negedge clk);
        exp_v = ref_model(v, z, daz, swc, cmp);
        n_checks++;
        if ({opnd_o, trap_req_o, trap_code_o} !== exp_v) begin
            n_fail++;
            $display("FAIL %s: in=%h z=%b daz=%b swc=%b cmp=%b got out=%h req=%b code=%b exp out=%h req=%b code=%b",
                     tag, v, z, daz, swc, cmp, opnd_o, trap_req_o, trap_code_o,
                     exp_v[67:4], exp_v[3], exp_v[2:0]);
        end
        // R9: request agrees with code
        n_checks++;
        if (trap_req_o !== (trap_code_o != 3'b000)) begin
            n_fail++;
            $display("FAIL R9: got req=%b code=%b exp req=%b", trap_req_o, trap_code_o,
                     (trap_code_o != 3'b000));
        end
    endtask

    function automatic logic [63:0] rand_opnd();
        logic [63:0] v;
        int k;
        v = {$urandom, $urandom};
        k = $urandom % 6;
        case (k)
            0: v[62:52] = 11'h000;
            1: v[62:52] = 11'h7ff;
            2: begin v[62:52] = 11'h7ff; v[51:0] = '0; end
            3: v[62:0] = '0;
            default: ;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: got %0d cycles exp completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: idle inputs give zero output
        @(negedge clk);
        n_checks++;
        if (opnd_o !== 64'd0 || trap_req_o !== 1'b0 || trap_code_o !== 3'd0) begin
            n_fail++;
            $display("FAIL R1: reset got out=%h req=%b code=%b exp 0 0 000", opnd_o, trap_req_o, trap_code_o);
        end
        // directed corners
        apply(64'h3ff0_0000_0000_0000, 0, 0, 0, 0, "R1");
        apply(64'hc009_21fb_5444_2d18, 0, 1, 0, 1, "R1");
        apply(64'h8000_0000_0000_0001, 0, 1, 0, 0, "R2");
        apply(64'h000f_ffff_ffff_ffff, 0, 1, 0, 1, "R2");
        apply(64'h0000_0000_0000_0001, 0, 0, 0, 0, "R3");
        apply(64'h8008_0000_0000_0000, 0, 0, 0, 1, "R3");
        apply(64'h7ff8_0000_0000_0000, 0, 0, 0, 0, "R4");
        apply(64'hfff0_0000_0000_0000, 0, 0, 0, 0, "R4");
        apply(64'h7ff0_0000_0000_0000, 0, 0, 0, 1, "R5");
        apply(64'hfff0_0000_0000_0001, 0, 1, 0, 1, "R5");
        apply(64'h8000_0000_0000_0abc, 0, 1, 1, 0, "R6");
        apply(64'h0000_0000_0000_0abc, 0, 0, 1, 0, "R6");
        apply(64'h7ff8_0000_0000_0001, 0, 0, 1, 0, "R6");
        apply(64'h7ff8_0000_0000_0001, 0, 0, 1, 1, "R7");
        apply(64'h7ff0_0000_0000_0000, 0, 0, 1, 1, "R7");
        apply(64'h7ff8_0000_0000_0000, 1, 0, 0, 0, "R8");
        apply(64'h0000_0000_0000_0005, 1, 0, 0, 1, "R8");
        for (int m = 0; m < 8; m++) begin
            apply(64'h0000_0000_0000_0000, 0, m[0], m[1], m[2], "R10");
            apply(64'h8000_0000_0000_0000, 0, m[0], m[1], m[2], "R10");
        end
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic z, d, s, c;
            v = rand_opnd();
            z = ($urandom % 8) == 0;
            d = $urandom % 2;
            s = ($urandom % 4) == 0;
            c = $urandom % 2;
            apply(v, z, d, s, c, tag_of(v, z, d, s, c));
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule